// File: doc/BRIEF.md
# System Control Coprocessor Register Access Unit

This block holds the registers of the system-control coprocessor and answers move-to and move-from coprocessor requests from the core. Each request carries a direction bit, the selector fields Op1, CRn, CRm and Op2, the index Rt of the general register involved, 32 bits of write data and the current privilege level. The block matches the whole selector tuple to one physical register. A read returns the register contents for the core to place in Rt. A write stores the Rt value in the register. A request that is not allowed is answered with an undefined-instruction flag.

Three registers are implemented. The first is a fixed identification word. The second is a fixed multiprocessor affinity word. The third is a system control register. Its MMU, data cache, branch prediction and instruction cache enable bits leave the block as separate control outputs. Every response appears exactly one clock after its request, together with a valid strobe, the fault flag and the echoed Rt index.

Top module: `sysreg_access_unit`

## Requirements
- R1: A request with `req_valid` high gives `rsp_valid` high on the next cycle. A cycle with no request gives `rsp_valid` low on the next cycle.
- R2: A read of tuple (Op1=0, CRn=0, CRm=0, Op2=0) returns the parameter `ID_VALUE` without a fault.
- R3: A read of tuple (Op1=0, CRn=0, CRm=0, Op2=1) returns the parameter `AFF_VALUE` without a fault.
- R4: Tuple (Op1=0, CRn=1, CRm=0, Op2=0) selects the control register. Its writable bits are bit 0 (MMU enable), bit 2 (data cache enable), bit 11 (branch prediction enable) and bit 12 (instruction cache enable). All other bits read as 0. After reset every bit is 0.
- R5: `ctl_mmu_en`, `ctl_dcache_en`, `ctl_bpred_en` and `ctl_icache_en` follow control register bits 0, 2, 11 and 12. A write takes effect in the same cycle as its response.
- R6: Any request at privilege PL0 (`req_priv` = 2'b00) raises `rsp_undef`, returns zero data and changes no register. The codes 2'b01 (PL1) and 2'b10 (PL2) are privileged.
- R7: A request with Rt = 15 raises `rsp_undef`, returns zero data and changes no register.
- R8: A tuple that matches no implemented register, including any tuple with a nonzero Op1 or CRm, raises `rsp_undef` and returns zero data.
- R9: A write to the identification or affinity register raises no fault and leaves the value read back unchanged.
- R10: `rsp_rt` echoes the Rt of the request. A write response carries zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write to the coprocessor register, 0 = read from it |
| req_op1 | input | 3 | Op1 selector |
| req_crn | input | 4 | Primary register number CRn |
| req_crm | input | 4 | Secondary register number CRm |
| req_op2 | input | 3 | Op2 selector |
| req_rt | input | 4 | General register index |
| req_wdata | input | 32 | Write data (the Rt value) |
| req_priv | input | 2 | Privilege level: 0 = PL0, 1 = PL1, 2 = PL2 |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data for Rt |
| rsp_rt | output | 4 | Echoed general register index |
| rsp_undef | output | 1 | Undefined-instruction flag |
| ctl_mmu_en | output | 1 | MMU enable |
| ctl_dcache_en | output | 1 | Data cache enable |
| ctl_bpred_en | output | 1 | Branch prediction enable |
| ctl_icache_en | output | 1 | Instruction cache enable |

## Verification
The assertions check the following on every cycle. Each response follows its request by one cycle. A PL0 request or an Rt=15 request always faults and leaves the enable outputs unchanged. A faulted response never carries nonzero data. The control register moves only on a permitted write. Only the scenarios in the bench can show the rest. These cover the exact identification and affinity values, the masking of non-writable control bits, the effect of each enable bit on its own output, rejection of tuples that differ from an implemented one in a single field, and writes to the read-only registers being dropped.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int DATA_W = 32;
    localparam int RT_W   = 4;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ID   = 2'd1,
        SEL_AFF  = 2'd2,
        SEL_CTL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sel_tuple_t;

    localparam sel_tuple_t KEY_ID  = '{op1: 3'd0, crn: 4'd0, crm: 4'd0, op2: 3'd0};
    localparam sel_tuple_t KEY_AFF = '{op1: 3'd0, crn: 4'd0, crm: 4'd0, op2: 3'd1};
    localparam sel_tuple_t KEY_CTL = '{op1: 3'd0, crn: 4'd1, crm: 4'd0, op2: 3'd0};

    localparam int CTL_MMU_BIT = 0;
    localparam int CTL_DC_BIT  = 2;
    localparam int CTL_BP_BIT  = 11;
    localparam int CTL_IC_BIT  = 12;

    localparam logic [DATA_W-1:0] CTL_WMASK =
        (DATA_W'(1) << CTL_MMU_BIT) | (DATA_W'(1) << CTL_DC_BIT) |
        (DATA_W'(1) << CTL_BP_BIT)  | (DATA_W'(1) << CTL_IC_BIT);

    localparam logic [1:0]      PRIV_PL0 = 2'd0;
    localparam logic [RT_W-1:0] RT_PC    = RT_W'(15);

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
    import sysreg_pkg::*;
(
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output reg_sel_e   sel
);

    sel_tuple_t key;

    always_comb begin
        key = '{op1: op1, crn: crn, crm: crm, op2: op2};
        unique case (key)
            KEY_ID:  sel = SEL_ID;
            KEY_AFF: sel = SEL_AFF;
            KEY_CTL: sel = SEL_CTL;
            default: sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/sysreg_guard.sv
module sysreg_guard
    import sysreg_pkg::*;
(
    input  logic [1:0]      priv,
    input  logic [RT_W-1:0] rt,
    input  reg_sel_e        sel,
    output logic            undef
);

    logic priv_bad;
    logic rt_bad;
    logic sel_bad;

    always_comb begin
        priv_bad = (priv == PRIV_PL0);
        rt_bad   = (rt == RT_PC);
        sel_bad  = (sel == SEL_NONE);
        undef    = priv_bad | rt_bad | sel_bad;
    end

endmodule

// File: rtl/sysreg_ctl.sv
module sysreg_ctl
    import sysreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctl_q
);

    logic [DATA_W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d = wdata & CTL_WMASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R4: without a write enable the register holds its value
    p_ctl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_q));

    // R4: a write lands the masked data
    p_ctl_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctl_q == ($past(wdata) & CTL_WMASK)));

endmodule

// File: rtl/sysreg_access_unit.sv
module sysreg_access_unit
    import sysreg_pkg::*;
#(
    parameter logic [31:0] ID_VALUE  = 32'h4A10_3C21,
    parameter logic [31:0] AFF_VALUE = 32'h8000_0002
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [2:0]  req_op1,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op2,
    input  logic [3:0]  req_rt,
    input  logic [31:0] req_wdata,
    input  logic [1:0]  req_priv,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic [3:0]  rsp_rt,
    output logic        rsp_undef,
    output logic        ctl_mmu_en,
    output logic        ctl_dcache_en,
    output logic        ctl_bpred_en,
    output logic        ctl_icache_en
);

    typedef struct packed {
        logic              valid;
        logic              undef;
        logic [RT_W-1:0]   rt;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t              rsp_d, rsp_q;
    reg_sel_e          sel;
    logic              undef;
    logic              ctl_wr;
    logic [DATA_W-1:0] ctl_val;

    sysreg_decode u_decode (
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .sel (sel)
    );

    sysreg_guard u_guard (
        .priv  (req_priv),
        .rt    (req_rt),
        .sel   (sel),
        .undef (undef)
    );

    sysreg_ctl u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ctl_wr),
        .wdata (req_wdata),
        .ctl_q (ctl_val)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.rt    = req_rt;
        rsp_d.undef = req_valid & undef;
        ctl_wr      = req_valid & req_write & ~undef & (sel == SEL_CTL);
        if (req_valid && !undef && !req_write) begin
            unique case (sel)
                SEL_ID:  rsp_d.rdata = ID_VALUE;
                SEL_AFF: rsp_d.rdata = AFF_VALUE;
                SEL_CTL: rsp_d.rdata = ctl_val;
                default: rsp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_undef     = rsp_q.undef;
    assign rsp_rt        = rsp_q.rt;
    assign rsp_rdata     = rsp_q.rdata;
    assign ctl_mmu_en    = ctl_val[CTL_MMU_BIT];
    assign ctl_dcache_en = ctl_val[CTL_DC_BIT];
    assign ctl_bpred_en  = ctl_val[CTL_BP_BIT];
    assign ctl_icache_en = ctl_val[CTL_IC_BIT];

    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_rsp_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_pl0_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv == PRIV_PL0) |=> (rsp_valid && rsp_undef));

    p_pl0_keeps_ctl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv == PRIV_PL0)
        |=> $stable({ctl_mmu_en, ctl_dcache_en, ctl_bpred_en, ctl_icache_en}));

    p_rt_pc_faults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_rt == RT_PC) |=> (rsp_valid && rsp_undef));

    p_rt_pc_keeps_ctl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_rt == RT_PC)
        |=> $stable({ctl_mmu_en, ctl_dcache_en, ctl_bpred_en, ctl_icache_en}));

    p_undef_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_undef) |-> (rsp_rdata == '0));

    p_rt_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_rt == $past(req_rt)));

endmodule

// File: tb/sysreg_access_unit_test.sv
module sysreg_access_unit_test;

    localparam logic [31:0] ID_V  = 32'h4A10_3C21;
    localparam logic [31:0] AFF_V = 32'h8000_0002;

    typedef struct packed {
        logic        wr;
        logic [2:0]  op1;
        logic [3:0]  crn;
        logic [3:0]  crm;
        logic [2:0]  op2;
        logic [3:0]  rt;
        logic [1:0]  priv;
        logic [31:0] wdata;
        logic        ex_undef;
        logic [31:0] ex_rdata;
        logic [3:0]  ex_ctl;   // {icache, bpred, dcache, mmu}
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 3'd0, 4'd0, 4'd0, 3'd0, 4'd1, 2'd1, 32'h0,         1'b0, ID_V,          4'h0, 4'd2},  // R2
        '{1'b0, 3'd0, 4'd0, 4'd0, 3'd1, 4'd2, 2'd1, 32'h0,         1'b0, AFF_V,         4'h0, 4'd3},  // R3
        '{1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 4'd3, 2'd1, 32'h0,         1'b0, 32'h0,         4'h0, 4'd4},  // R4
        '{1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 4'd4, 2'd1, 32'hFFFF_FFFF, 1'b0, 32'h0,         4'hF, 4'd5},  // R5 R10
        '{1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 4'd5, 2'd1, 32'h0,         1'b0, 32'h0000_1805, 4'hF, 4'd4},  // R4 mask
        '{1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 4'd6, 2'd2, 32'h0000_0804, 1'b0, 32'h0,         4'h6, 4'd5},  // R5
        '{1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 4'd7, 2'd1, 32'h0,         1'b0, 32'h0000_0804, 4'h6, 4'd4},  // R4
        '{1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 4'd8, 2'd0, 32'hFFFF_FFFF, 1'b1, 32'h0,         4'h6, 4'd6},  // R6
        '{1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 4'd9, 2'd0, 32'h0,         1'b1, 32'h0,         4'h6, 4'd6},  // R6
        '{1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 4'd15, 2'd1, 32'h0,        1'b1, 32'h0,         4'h6, 4'd7},  // R7
        '{1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 4'd15, 2'd1, 32'h0,        1'b1, 32'h0,         4'h6, 4'd7},  // R7
        '{1'b0, 3'd0, 4'd0, 4'd0, 3'd2, 4'd1, 2'd1, 32'h0,         1'b1, 32'h0,         4'h6, 4'd8},  // R8
        '{1'b0, 3'd1, 4'd1, 4'd0, 3'd0, 4'd1, 2'd1, 32'h0,         1'b1, 32'h0,         4'h6, 4'd8},  // R8
        '{1'b0, 3'd0, 4'd1, 4'd1, 3'd0, 4'd1, 2'd1, 32'h0,         1'b1, 32'h0,         4'h6, 4'd8},  // R8
        '{1'b1, 3'd0, 4'd0, 4'd0, 3'd0, 4'd10, 2'd1, 32'h0,        1'b0, 32'h0,         4'h6, 4'd9},  // R9
        '{1'b0, 3'd0, 4'd0, 4'd0, 3'd0, 4'd11, 2'd1, 32'h0,        1'b0, ID_V,          4'h6, 4'd9},  // R9
        '{1'b1, 3'd0, 4'd0, 4'd0, 3'd1, 4'd12, 2'd1, 32'h1234_5678, 1'b0, 32'h0,        4'h6, 4'd9},  // R9
        '{1'b0, 3'd0, 4'd0, 4'd0, 3'd1, 4'd13, 2'd2, 32'h0,        1'b0, AFF_V,         4'h6, 4'd9},  // R9
        '{1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 4'd14, 2'd2, 32'h0000_1000, 1'b0, 32'h0,        4'h8, 4'd5},  // R5
        '{1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 4'd0, 2'd1, 32'h0,         1'b0, 32'h0000_1000, 4'h8, 4'd4}   // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_op1 = '0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_op2 = '0;
    logic [3:0]  req_rt = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_priv = 2'd1;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  rsp_rt;
    logic        rsp_undef;
    logic        ctl_mmu_en, ctl_dcache_en, ctl_bpred_en, ctl_icache_en;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    sysreg_access_unit #(.ID_VALUE(ID_V), .AFF_VALUE(AFF_V)) uut (
        .clk, .rst_n, .req_valid, .req_write, .req_op1, .req_crn, .req_crm,
        .req_op2, .req_rt, .req_wdata, .req_priv, .rsp_valid, .rsp_rdata,
        .rsp_rt, .rsp_undef, .ctl_mmu_en, .ctl_dcache_en, .ctl_bpred_en,
        .ctl_icache_en
    );

    function automatic logic [3:0] ctl4();
        return {ctl_icache_en, ctl_bpred_en, ctl_dcache_en, ctl_mmu_en};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R4 reset state, R1 no response
        check("R4 reset ctl", 32'(ctl4()), 32'h0);
        check("R1 reset rsp_valid", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle rsp_valid", 32'(rsp_valid), 32'h0);

        for (int i = 0; i < NV; i++) begin
            req_valid = 1'b1;
            req_write = TBL[i].wr;
            req_op1   = TBL[i].op1;
            req_crn   = TBL[i].crn;
            req_crm   = TBL[i].crm;
            req_op2   = TBL[i].op2;
            req_rt    = TBL[i].rt;
            req_priv  = TBL[i].priv;
            req_wdata = TBL[i].wdata;
            @(negedge clk);
            req_valid = 1'b0;
            check($sformatf("R1 valid v%0d", i), 32'(rsp_valid), 32'h1);
            check($sformatf("R%0d undef v%0d", TBL[i].req, i), 32'(rsp_undef), 32'(TBL[i].ex_undef));
            check($sformatf("R%0d rdata v%0d", TBL[i].req, i), rsp_rdata, TBL[i].ex_rdata);
            check($sformatf("R5 ctl v%0d", i), 32'(ctl4()), 32'(TBL[i].ex_ctl));
            check($sformatf("R10 rt v%0d", i), 32'(rsp_rt), 32'(TBL[i].rt));
        end

        @(negedge clk);
        check("R1 idle after burst", 32'(rsp_valid), 32'h0);

        // R1 back-to-back requests, R5 each output alone
        req_valid = 1'b1; req_write = 1'b1; req_priv = 2'd1; req_rt = 4'd3;
        req_op1 = 3'd0; req_crn = 4'd1; req_crm = 4'd0; req_op2 = 3'd0;
        req_wdata = 32'h0000_0001;
        @(negedge clk);
        check("R5 mmu only", 32'(ctl4()), 32'h1);
        req_wdata = 32'h0000_0004;
        @(negedge clk);
        check("R1 back-to-back valid", 32'(rsp_valid), 32'h1);
        check("R5 dcache only", 32'(ctl4()), 32'h2);
        req_wdata = 32'hFFFF_E7FA;
        @(negedge clk);
        req_valid = 1'b0;
        check("R4 non-writable bits", 32'(ctl4()), 32'h0);

        // R4 reset clears the control register mid-run
        req_valid = 1'b1; req_wdata = 32'h0000_1805;
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 all set", 32'(ctl4()), 32'hF);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R4 reset clears ctl", 32'(ctl4()), 32'h0);
        check("R1 reset clears valid", 32'(rsp_valid), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule